// File: doc/BRIEF.md
# Serial Mode-Control Port

This block receives configuration words over a slow three-line serial link (a shift clock, a data line and a framing strobe) and holds them in two 10-bit mode banks. A fast system clock oversamples all three lines through synchronizers, so the serial link may run at any rate far below the system clock. The host pulls the strobe low, clocks in twelve bits with the first bit leading, then returns the strobe high. The word takes effect only at that rising strobe edge.

Of the twelve bits, the leading one is a select bit that must be low for the word to be taken. The second bit picks the bank. The ten remaining payload bits, called D1 (earliest) to D10 (latest), fill the chosen bank. The block decodes both banks into control levels: the input path, the filters, the mutes, the front-mix phase and level, the echo delay code, system mute and the sample-clock speed. A word carrying a reserved code is refused and raises an illegal-code flag.

Top module: `serctl_port`

## Requirements
- R1: Reset state: bank 0 holds D1..D10 = 0001100011 and bank 1 holds all zeros, so:
  - `adc_mute_o`, `main_mute_o`, `aux_mute_o`, `sys_mute_o` and `clk_fast_o` are 1.
  - `front_lvl_o` is 11.
  - Every other output is 0, including `illegal_o`.
- R2: A word whose leading (select) bit is 1 changes no output.
- R3: A word is taken only if exactly 12 shift-clock rising edges occurred while the strobe was low. With 11 or 13 edges the word is dropped and no output changes.
- R4: Bank 0 (second bit 0) drives these outputs:
  - `in_lpf_en_o` = D1, `in_diff_o` = D2 and `in_aux_o` = D3.
  - `main_mute_o` = NOT D6 and `aux_mute_o` = NOT D7.
  - `front_inv_o` = D8.
- R5: The bank-0 path code {D4,D5} decodes as:
  - 00 sets `in_bypass_o`.
  - 10 sets `in_filt_o`.
  - 11 sets `adc_mute_o`.
  - At most one of the three is high at any time.
- R6: `front_lvl_o` = {D9,D10}, with 00 = +3 dB, 01 = 0 dB, 10 = -3 dB and 11 = muted.
- R7: Bank 1 (second bit 1) drives these outputs:
  - `aux_lpf_en_o` is 1 only when {D1,D2} = 01.
  - `delay_code_o` = {D6,D7,D8}, with D6 as the MSB, selecting delay steps 1 to 6.
  - `sys_mute_o` = NOT D9 and `clk_fast_o` = NOT D10.
  - D3..D5 are ignored.
- R8: An otherwise valid word is refused if it carries bank-0 path code 01 or a bank-1 delay code of 110 or 111. The bank keeps its previous contents and `illegal_o` goes to 1. The next accepted legal word clears `illegal_o`.
- R9: Outputs change only after the strobe's rising edge. They hold their old values while the bits are being shifted in.
- R10: Writing one bank leaves the other bank's outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the link |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk_i | input | 1 | Serial shift clock, idles high |
| ser_dat_i | input | 1 | Serial data, sampled on shift-clock rise |
| ser_en_i | input | 1 | Framing strobe, low during a word, rising edge commits |
| in_lpf_en_o | output | 1 | Input low-pass filter enable |
| in_diff_o | output | 1 | Input uses difference (1) or sum (0) |
| in_aux_o | output | 1 | Input taken from auxiliary source |
| in_bypass_o | output | 1 | Delay path fed directly |
| in_filt_o | output | 1 | Delay path fed through filter |
| adc_mute_o | output | 1 | Converter input muted |
| main_mute_o | output | 1 | Main outputs muted |
| aux_mute_o | output | 1 | Auxiliary output muted |
| front_inv_o | output | 1 | Front mix added in inverted phase |
| front_lvl_o | output | 2 | Front mix level code |
| aux_lpf_en_o | output | 1 | Auxiliary output filter enable |
| delay_code_o | output | 3 | Echo delay step code |
| sys_mute_o | output | 1 | System mute |
| clk_fast_o | output | 1 | Fast sample clock selected |
| illegal_o | output | 1 | Last accepted word carried a reserved code |

## Verification
The hardest condition to reach is a frame that is complete and well-formed at the bit level but still refused, because it carries a reserved code. The bench checks that the bank is left untouched and that the flag follows the rejection. It then clears the flag with a following legal word.

Frames of 11 and 13 bits are driven by a task that produces any bit count. This lets the bench check that the commit gate depends on the bit count and not only on the strobe edge.

The bench also samples the outputs while the last bit has been shifted in but the strobe is still low. This shows that nothing is committed early.

// File: rtl/serctl_pkg.sv
package serctl_pkg;

  localparam int unsigned WORD_W = 12;
  localparam int unsigned PAY_W  = WORD_W - 2;
  localparam int unsigned DLY_W  = 3;
  localparam int unsigned DLY_LAST = 5;

  // payload bit positions: D1 arrives first and sits at the MSB
  localparam int unsigned P_D1  = PAY_W - 1;
  localparam int unsigned P_D2  = PAY_W - 2;
  localparam int unsigned P_D3  = PAY_W - 3;
  localparam int unsigned P_D4  = PAY_W - 4;
  localparam int unsigned P_D5  = PAY_W - 5;
  localparam int unsigned P_D6  = PAY_W - 6;
  localparam int unsigned P_D8  = PAY_W - 8;
  localparam int unsigned P_D7  = PAY_W - 7;
  localparam int unsigned P_D9  = PAY_W - 9;
  localparam int unsigned P_D10 = PAY_W - 10;

  typedef enum logic [1:0] {
    PATH_THRU = 2'b00,
    PATH_RSVD = 2'b01,
    PATH_FILT = 2'b10,
    PATH_MUTE = 2'b11
  } path_e;

  // reset payloads: everything muted, system mute on, fast clock
  localparam logic [PAY_W-1:0] BANK0_RST = 10'b0001100011;
  localparam logic [PAY_W-1:0] BANK1_RST = 10'b0000000000;

endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int unsigned W = 3,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  logic [W-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
      s3_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign q_o = s2_q;

  for (genvar i = 0; i < W; i++) begin : g_edge
    assign rise_o[i] = s2_q[i] & ~s3_q[i];
    assign fall_o[i] = ~s2_q[i] & s3_q[i];
  end

endmodule

// File: rtl/serctl_shift.sv
module serctl_shift #(
  parameter int unsigned WORD_W = 12,
  localparam int unsigned CNT_W = $clog2(WORD_W + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_i,
  input  logic              shift_i,
  input  logic              clear_i,
  output logic [WORD_W-1:0] word_o,
  output logic [CNT_W-1:0]  cnt_o
);

  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(WORD_W + 1);

  logic [WORD_W-1:0] word_q, word_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (shift_i) begin
      word_d = {word_q[WORD_W-2:0], bit_i};
      if (cnt_q != CNT_SAT) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end

  assign word_o = word_q;
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/serctl_cmd.sv
module serctl_cmd
  import serctl_pkg::*;
#(
  parameter int unsigned WORD_W = serctl_pkg::WORD_W,
  localparam int unsigned CNT_W = $clog2(WORD_W + 2),
  localparam int unsigned PW    = WORD_W - 2
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              commit_i,
  output logic              accept_o,
  output logic              bad_o,
  output logic              wr0_o,
  output logic              wr1_o,
  output logic [PW-1:0]     pay_o
);

  logic          sel_n, bank;
  path_e         path;
  logic [DLY_W-1:0] dly;
  logic          bad0, bad1;

  assign sel_n = word_i[WORD_W-1];
  assign bank  = word_i[WORD_W-2];
  assign pay_o = word_i[PW-1:0];
  assign path  = path_e'({pay_o[P_D4], pay_o[P_D5]});
  assign dly   = {pay_o[P_D6], pay_o[P_D7], pay_o[P_D8]};

  always_comb begin
    bad0 = (path == PATH_RSVD);
    bad1 = (dly > DLY_W'(DLY_LAST));
    accept_o = commit_i && (cnt_i == CNT_W'(WORD_W)) && !sel_n;
    bad_o = bank ? bad1 : bad0;
    wr0_o = accept_o && !bank && !bad0;
    wr1_o = accept_o &&  bank && !bad1;
  end

endmodule

// File: rtl/serctl_fields.sv
module serctl_fields
  import serctl_pkg::*;
(
  input  logic [PAY_W-1:0] b0_i,
  input  logic [PAY_W-1:0] b1_i,
  output logic             in_lpf_en_o,
  output logic             in_diff_o,
  output logic             in_aux_o,
  output logic             in_bypass_o,
  output logic             in_filt_o,
  output logic             adc_mute_o,
  output logic             main_mute_o,
  output logic             aux_mute_o,
  output logic             front_inv_o,
  output logic [1:0]       front_lvl_o,
  output logic             aux_lpf_en_o,
  output logic [DLY_W-1:0] delay_code_o,
  output logic             sys_mute_o,
  output logic             clk_fast_o
);

  path_e path;

  always_comb begin
    path         = path_e'({b0_i[P_D4], b0_i[P_D5]});
    in_lpf_en_o  = b0_i[P_D1];
    in_diff_o    = b0_i[P_D2];
    in_aux_o     = b0_i[P_D3];
    in_bypass_o  = (path == PATH_THRU);
    in_filt_o    = (path == PATH_FILT);
    adc_mute_o   = (path == PATH_MUTE);
    main_mute_o  = ~b0_i[P_D6];
    aux_mute_o   = ~b0_i[P_D7];
    front_inv_o  = b0_i[P_D8];
    front_lvl_o  = {b0_i[P_D9], b0_i[P_D10]};
    aux_lpf_en_o = ({b1_i[P_D1], b1_i[P_D2]} == 2'b01);
    delay_code_o = {b1_i[P_D6], b1_i[P_D7], b1_i[P_D8]};
    sys_mute_o   = ~b1_i[P_D9];
    clk_fast_o   = ~b1_i[P_D10];
  end

endmodule

// File: rtl/serctl_port.sv
module serctl_port
  import serctl_pkg::*;
#(
  parameter int unsigned WORD_W = serctl_pkg::WORD_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_clk_i,
  input  logic       ser_dat_i,
  input  logic       ser_en_i,
  output logic       in_lpf_en_o,
  output logic       in_diff_o,
  output logic       in_aux_o,
  output logic       in_bypass_o,
  output logic       in_filt_o,
  output logic       adc_mute_o,
  output logic       main_mute_o,
  output logic       aux_mute_o,
  output logic       front_inv_o,
  output logic [1:0] front_lvl_o,
  output logic       aux_lpf_en_o,
  output logic [2:0] delay_code_o,
  output logic       sys_mute_o,
  output logic       clk_fast_o,
  output logic       illegal_o
);

  localparam int unsigned CNT_W = $clog2(WORD_W + 2);
  localparam int unsigned PW    = WORD_W - 2;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  // line synchronizers: bit 2 strobe, bit 1 data, bit 0 shift clock
  logic [2:0] line_q, line_rise, line_fall;

  serctl_sync #(.W(3), .RST_VAL(3'b111)) u_sync (
    .clk    (clk),
    .rst_n  (rst_ni),
    .d_i    ({ser_en_i, ser_dat_i, ser_clk_i}),
    .q_o    (line_q),
    .rise_o (line_rise),
    .fall_o (line_fall)
  );

  logic en_rise, en_fall, en_low, sclk_rise, shift_en;
  assign en_rise   = line_rise[2];
  assign en_fall   = line_fall[2];
  assign en_low    = ~line_q[2];
  assign sclk_rise = line_rise[0];
  assign shift_en  = sclk_rise & en_low;

  logic [WORD_W-1:0] word;
  logic [CNT_W-1:0]  cnt;

  serctl_shift #(.WORD_W(WORD_W)) u_shift (
    .clk     (clk),
    .rst_n   (rst_ni),
    .bit_i   (line_q[1]),
    .shift_i (shift_en),
    .clear_i (en_fall),
    .word_o  (word),
    .cnt_o   (cnt)
  );

  logic          frame_ok, bad, wr0, wr1;
  logic [PW-1:0] pay;

  serctl_cmd #(.WORD_W(WORD_W)) u_cmd (
    .word_i   (word),
    .cnt_i    (cnt),
    .commit_i (en_rise),
    .accept_o (frame_ok),
    .bad_o    (bad),
    .wr0_o    (wr0),
    .wr1_o    (wr1),
    .pay_o    (pay)
  );

  // mode banks
  logic [PW-1:0] bank0_q, bank0_d, bank1_q, bank1_d;
  logic          illegal_q, illegal_d;

  always_comb begin
    bank0_d   = wr0 ? pay : bank0_q;
    bank1_d   = wr1 ? pay : bank1_q;
    illegal_d = frame_ok ? bad : illegal_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      bank0_q   <= BANK0_RST;
      bank1_q   <= BANK1_RST;
      illegal_q <= 1'b0;
    end else begin
      bank0_q   <= bank0_d;
      bank1_q   <= bank1_d;
      illegal_q <= illegal_d;
    end
  end

  assign illegal_o = illegal_q;

  serctl_fields u_fields (
    .b0_i         (bank0_q),
    .b1_i         (bank1_q),
    .in_lpf_en_o  (in_lpf_en_o),
    .in_diff_o    (in_diff_o),
    .in_aux_o     (in_aux_o),
    .in_bypass_o  (in_bypass_o),
    .in_filt_o    (in_filt_o),
    .adc_mute_o   (adc_mute_o),
    .main_mute_o  (main_mute_o),
    .aux_mute_o   (aux_mute_o),
    .front_inv_o  (front_inv_o),
    .front_lvl_o  (front_lvl_o),
    .aux_lpf_en_o (aux_lpf_en_o),
    .delay_code_o (delay_code_o),
    .sys_mute_o   (sys_mute_o),
    .clk_fast_o   (clk_fast_o)
  );

endmodule

// File: rtl/serctl_chk.sv
module serctl_chk #(
  parameter int unsigned PW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_ok,
  input logic [PW-1:0] bank0_q,
  input logic [PW-1:0] bank1_q,
  input logic          illegal_o,
  input logic [2:0]    delay_code_o,
  input logic          sys_mute_o,
  input logic          main_mute_o,
  input logic          aux_mute_o,
  input logic          adc_mute_o,
  input logic          in_bypass_o,
  input logic          in_filt_o
);

  a_r1_reset_muted: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sys_mute_o && main_mute_o && aux_mute_o && adc_mute_o && !illegal_o));

  // R3, R9: banks move only right after an accepted frame
  a_r3_commit_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(bank0_q) || !$stable(bank1_q)) |-> $past(frame_ok));

  a_r8_refused_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(illegal_o) |-> ($stable(bank0_q) && $stable(bank1_q)));

  a_r7_delay_legal: assert property (@(posedge clk) disable iff (!rst_n)
    delay_code_o <= 3'd5);

  a_r5_path_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({in_bypass_o, in_filt_o, adc_mute_o}));

endmodule

bind serctl_port serctl_chk #(.PW(PW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .frame_ok     (frame_ok),
  .bank0_q      (bank0_q),
  .bank1_q      (bank1_q),
  .illegal_o    (illegal_o),
  .delay_code_o (delay_code_o),
  .sys_mute_o   (sys_mute_o),
  .main_mute_o  (main_mute_o),
  .aux_mute_o   (aux_mute_o),
  .adc_mute_o   (adc_mute_o),
  .in_bypass_o  (in_bypass_o),
  .in_filt_o    (in_filt_o)
);

// File: tb/sim_serctl_port.sv
module sim_serctl_port;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sdat = 1'b1, sen = 1'b1;
  always #5 clk = ~clk;

  logic in_lpf_en_o, in_diff_o, in_aux_o, in_bypass_o, in_filt_o, adc_mute_o;
  logic main_mute_o, aux_mute_o, front_inv_o, aux_lpf_en_o, sys_mute_o, clk_fast_o, illegal_o;
  logic [1:0] front_lvl_o;
  logic [2:0] delay_code_o;

  serctl_port u0 (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_en_i(sen),
    .in_lpf_en_o(in_lpf_en_o), .in_diff_o(in_diff_o), .in_aux_o(in_aux_o),
    .in_bypass_o(in_bypass_o), .in_filt_o(in_filt_o), .adc_mute_o(adc_mute_o),
    .main_mute_o(main_mute_o), .aux_mute_o(aux_mute_o), .front_inv_o(front_inv_o),
    .front_lvl_o(front_lvl_o), .aux_lpf_en_o(aux_lpf_en_o), .delay_code_o(delay_code_o),
    .sys_mute_o(sys_mute_o), .clk_fast_o(clk_fast_o), .illegal_o(illegal_o)
  );

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  typedef struct {
    string       tag;
    logic [10:0] e0;
    logic [5:0]  e1;
    logic        eil;
  } item_t;
  item_t sb[$];

  // reference model state, D1 at bit 9
  logic [9:0] m0, m1;
  logic       mil;

  function automatic logic [10:0] f0(input logic [9:0] p);
    return {p[9], p[8], p[7], p[6:5] == 2'b00, p[6:5] == 2'b10, p[6:5] == 2'b11,
            ~p[4], ~p[3], p[2], p[1:0]};
  endfunction

  function automatic logic [5:0] f1(input logic [9:0] p);
    return {p[9:8] == 2'b01, p[4:2], ~p[1], ~p[0]};
  endfunction

  function automatic logic [10:0] act0();
    return {in_lpf_en_o, in_diff_o, in_aux_o, in_bypass_o, in_filt_o, adc_mute_o,
            main_mute_o, aux_mute_o, front_inv_o, front_lvl_o};
  endfunction

  function automatic logic [5:0] act1();
    return {aux_lpf_en_o, delay_code_o, sys_mute_o, clk_fast_o};
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic model(input logic [11:0] w, input int nb);
    logic bad;
    if (nb == 12 && w[11] == 1'b0) begin
      if (w[10]) bad = (w[4:2] > 3'd5);
      else       bad = (w[6:5] == 2'b01);
      mil = bad;
      if (!bad) begin
        if (w[10]) m1 = w[9:0];
        else       m0 = w[9:0];
      end
    end
  endtask

  // driver: shifts nb bits (first bit leading), then commits
  task automatic send(input logic [11:0] w, input int nb, input string tag);
    item_t it;
    sen = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = nb - 1; i >= 0; i--) begin
      sclk = 1'b0;
      sdat = (i < 12) ? w[i] : 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    // R9: all bits in, strobe still low: nothing applied yet
    chk({tag, " R9 bank0 early"}, 16'(act0()), 16'(f0(m0)));
    chk({tag, " R9 bank1 early"}, 16'(act1()), 16'(f1(m1)));
    sen = 1'b1;
    model(w, nb);
    it.tag = tag; it.e0 = f0(m0); it.e1 = f1(m1); it.eil = mil;
    sb.push_back(it);
    repeat (24) @(negedge clk);
  endtask

  // monitor: pops expectations and compares once the commit has settled
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        repeat (12) @(negedge clk);
        it = sb.pop_front();
        chk({it.tag, " bank0 fields R4"}, 16'(act0()), 16'(it.e0));
        chk({it.tag, " bank1 fields R7"}, 16'(act1()), 16'(it.e1));
        chk({it.tag, " flag R8"}, 16'(illegal_o), 16'(it.eil));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R1 got=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    m0 = 10'b0001100011; m1 = 10'b0; mil = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 reset values
    chk("R1 bank0 reset", 16'(act0()), 16'(11'b00000111011));
    chk("R1 bank1 reset", 16'(act1()), 16'(6'b000011));
    chk("R1 flag reset", 16'(illegal_o), 16'(1'b0));

    send({2'b00, 10'b1101011101}, 12, "R4 R5 R6 bank0 filter");
    send({2'b00, 10'b0010001010}, 12, "R5 R6 bank0 through");
    send({2'b01, 10'b0111101111}, 12, "R7 bank1 set");
    send({2'b01, 10'b0000010110}, 12, "R7 R10 bank1 other");
    send({2'b10, 10'b1111111100}, 12, "R2 deselected");
    send({2'b00, 10'b0000000000}, 11, "R3 short word");
    send({2'b00, 10'b0000000000}, 13, "R3 long word");
    send({2'b00, 10'b0000100000}, 12, "R8 bank0 reserved path");
    send({2'b01, 10'b0000011011}, 12, "R8 bank1 delay 110");
    send({2'b01, 10'b0100000100}, 12, "R8 clear by legal");
    send({2'b01, 10'b0000011111}, 12, "R8 bank1 delay 111");
    send({2'b00, 10'b1111101111}, 12, "R5 R6 R10 bank0 muted path");
    send({2'b01, 10'b1000000000}, 12, "R7 aux filter 10 off");

    while (sb.size() > 0) @(negedge clk);
    repeat (30) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule